// File: doc/BRIEF.md
# Registered Narrow-to-Wide Bus Exchanger

This block moves data between a 12-bit narrow port A and a 24-bit wide port B. Port B is split into a low half (1B) and a high half (2B). Every storage element in the block is a clocked register with its own active-low clock enable, so software-free control logic can steer words through it one cycle at a time.

In the A-to-B direction the low half passes through two register stages and the high half through one. This lets two narrow words that arrive on consecutive cycles leave together as one wide word. The A-to-B stage-one enable is lowered for the first word. All three A-to-B enables are then lowered for the second word. After that edge, B carries the first word in its low half and the second in its high half, and keeps them for as long as the enables stay high.

In the B-to-A direction, each half of B has its own capture register. A registered select chooses which of the two drives A. The drive of both ports comes from registered active-low enable requests, so a change of bus direction only ever takes effect on a rising clock edge. The tristate pins are modelled as separate input, output and output-enable signals. The block has no valid/ready handshake: data moves only when the clock enables say so, and nothing ever pushes back.

Top module: `narrow_wide_xchg`

## Requirements
- R1: Each A-to-B data register loads its input on a rising `clk` edge only when its clock enable is 0, and keeps its value on every edge where that enable is 1.
- R2: The low half of `b_out` is the second of two A-to-B stages. `ce_lo1_n`=0 loads `a_in` into stage one, and `ce_lo2_n`=0 moves stage one into `b_out[NW-1:0]`. A word therefore needs two enabled edges to reach 1B.
- R3: The high half `b_out[2*NW-1:NW]` is a single register that loads `a_in` on an edge where `ce_hi_n` is 0.
- R4: `src_sel` is registered. After an edge that samples 0, `a_out` shows the 1B capture register; after an edge that samples 1, it shows the 2B capture register. A change of `src_sel` has no effect on `a_out` before the next rising edge.
- R5: `a_oe` equals the inverse of `a_drv_n`, and `b_oe` the inverse of `b_drv_n`, as sampled on the previous rising edge. Neither output changes between edges.
- R6: For words X and then Y on `a_in`, the sequence is: `ce_lo1_n`=0 alone on the first edge, then all three A-to-B enables at 0 on the second edge. After the second edge, `b_out` = {Y, X}, and it holds that value while all A-to-B enables are 1.
- R7: With `rst`=1 on a rising edge, the block clears every data register to zero, sets the select to the 1B side (0), and sets `a_oe` and `b_oe` to 0 (high impedance).
- R8: The 1B capture register loads `b_in[NW-1:0]` when `ce_ba_lo_n` is 0, and the 2B capture register loads `b_in[2*NW-1:NW]` when `ce_ba_hi_n` is 0. Each holds its value when its enable is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | NW | Narrow port, data arriving from the pins |
| a_out | output | NW | Narrow port, data driven to the pins |
| a_oe | output | 1 | Narrow port drive enable (1 = drive) |
| b_in | input | 2*NW | Wide port, data arriving from the pins |
| b_out | output | 2*NW | Wide port, data driven to the pins ({2B, 1B}) |
| b_oe | output | 1 | Wide port drive enable (1 = drive) |
| src_sel | input | 1 | Select for A output: 0 = 1B capture, 1 = 2B capture |
| a_drv_n | input | 1 | Active-low request to drive port A |
| b_drv_n | input | 1 | Active-low request to drive port B |
| ce_lo1_n | input | 1 | Active-low enable, A-to-1B stage one |
| ce_lo2_n | input | 1 | Active-low enable, A-to-1B stage two |
| ce_hi_n | input | 1 | Active-low enable, A-to-2B register |
| ce_ba_lo_n | input | 1 | Active-low enable, 1B-to-A capture |
| ce_ba_hi_n | input | 1 | Active-low enable, 2B-to-A capture |

## Verification
The bench builds the block with the default NW = 12. Random 12-bit words can therefore land in either half of B, and a mix-up between the halves or between pipeline stages shows as a value mismatch rather than a coincidence. The five clock enables, the select, both drive requests and occasional resets are drawn independently every cycle. This reaches pipelines stalled in one stage only, select changes while a capture register loads, and direction changes in back-to-back cycles. Directed passes add the word-pairing sequence and the timing of enable changes between edges.

// File: rtl/xchg_pkg.sv
package xchg_pkg;

  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_e;

  localparam int HALVES = 2;

endpackage

// File: rtl/xchg_reg.sv
module xchg_reg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (!ce_n) q <= d;
  end

  // R1
  hold_when_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    ce_n |=> $stable(q));

  // R1
  load_when_enabled_chk: assert property (@(posedge clk) disable iff (rst)
    !ce_n |=> q == $past(d));

  // R7
  clear_on_reset_chk: assert property (@(posedge clk)
    rst |=> q == '0);

endmodule

// File: rtl/xchg_ctl.sv
module xchg_ctl
  import xchg_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  src_sel,
  input  logic  a_drv_n,
  input  logic  b_drv_n,
  output half_e sel_q,
  output logic  a_oe,
  output logic  b_oe
);

  // Drive is stored active high so the cleared state means high impedance.
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= HALF_LO;
      a_oe  <= 1'b0;
      b_oe  <= 1'b0;
    end else begin
      sel_q <= half_e'(src_sel);
      a_oe  <= ~a_drv_n;
      b_oe  <= ~b_drv_n;
    end
  end

  // R5
  a_drive_follows_request_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> a_oe == !$past(a_drv_n));

  // R5
  b_drive_follows_request_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> b_oe == !$past(b_drv_n));

  // R7
  reset_releases_bus_chk: assert property (@(posedge clk)
    rst |=> !a_oe && !b_oe && sel_q == HALF_LO);

endmodule

// File: rtl/xchg_bta.sv
module xchg_bta
  import xchg_pkg::*;
#(
  parameter int NW = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2*NW-1:0]   b_in,
  input  logic              ce_ba_lo_n,
  input  logic              ce_ba_hi_n,
  input  half_e             sel_q,
  output logic [NW-1:0]     a_out
);

  logic [HALVES-1:0] ce_n;
  logic [NW-1:0]     half_q [HALVES];

  assign ce_n = {ce_ba_hi_n, ce_ba_lo_n};

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    xchg_reg #(.W(NW)) u_cap (
      .clk  (clk),
      .rst  (rst),
      .ce_n (ce_n[h]),
      .d    (b_in[h*NW +: NW]),
      .q    (half_q[h])
    );
  end

  always_comb begin
    a_out = half_q[0];
    if (sel_q == HALF_HI) a_out = half_q[1];
  end

  // R8
  lo_capture_reaches_a_chk: assert property (@(posedge clk) disable iff (rst)
    (!ce_ba_lo_n && !ce_ba_hi_n) |=> (a_out == $past(b_in[NW-1:0]) ||
                                      a_out == $past(b_in[2*NW-1:NW])));

endmodule

// File: rtl/narrow_wide_xchg.sv
module narrow_wide_xchg
  import xchg_pkg::*;
#(
  parameter int NW = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NW-1:0]   a_in,
  output logic [NW-1:0]   a_out,
  output logic            a_oe,
  input  logic [2*NW-1:0] b_in,
  output logic [2*NW-1:0] b_out,
  output logic            b_oe,
  input  logic            src_sel,
  input  logic            a_drv_n,
  input  logic            b_drv_n,
  input  logic            ce_lo1_n,
  input  logic            ce_lo2_n,
  input  logic            ce_hi_n,
  input  logic            ce_ba_lo_n,
  input  logic            ce_ba_hi_n
);

  localparam int WW = 2 * NW;

  logic [NW-1:0] lo_s1_q;
  logic [NW-1:0] lo_s2_q;
  logic [NW-1:0] hi_q;
  half_e         sel_q;

  xchg_reg #(.W(NW)) u_lo_s1 (
    .clk (clk), .rst (rst), .ce_n (ce_lo1_n), .d (a_in), .q (lo_s1_q)
  );

  xchg_reg #(.W(NW)) u_lo_s2 (
    .clk (clk), .rst (rst), .ce_n (ce_lo2_n), .d (lo_s1_q), .q (lo_s2_q)
  );

  xchg_reg #(.W(NW)) u_hi (
    .clk (clk), .rst (rst), .ce_n (ce_hi_n), .d (a_in), .q (hi_q)
  );

  assign b_out = {hi_q, lo_s2_q};

  xchg_ctl u_ctl (
    .clk     (clk),
    .rst     (rst),
    .src_sel (src_sel),
    .a_drv_n (a_drv_n),
    .b_drv_n (b_drv_n),
    .sel_q   (sel_q),
    .a_oe    (a_oe),
    .b_oe    (b_oe)
  );

  xchg_bta #(.NW(NW)) u_bta (
    .clk        (clk),
    .rst        (rst),
    .b_in       (b_in),
    .ce_ba_lo_n (ce_ba_lo_n),
    .ce_ba_hi_n (ce_ba_hi_n),
    .sel_q      (sel_q),
    .a_out      (a_out)
  );

  // R2
  lo_half_from_stage_one_chk: assert property (@(posedge clk) disable iff (rst)
    !ce_lo2_n |=> b_out[NW-1:0] == $past(lo_s1_q));

  // R3
  hi_half_from_port_a_chk: assert property (@(posedge clk) disable iff (rst)
    !ce_hi_n |=> b_out[WW-1:NW] == $past(a_in));

  // R6
  pair_held_chk: assert property (@(posedge clk) disable iff (rst)
    (ce_lo2_n && ce_hi_n) |=> $stable(b_out));

endmodule

// File: tb/test_narrow_wide_xchg.sv
module test_narrow_wide_xchg;

  localparam int NW = 12;
  localparam int WW = 2 * NW;

  logic          clk = 1'b0;
  logic          rst;
  logic [NW-1:0] a_in, a_out;
  logic [WW-1:0] b_in, b_out;
  logic          a_oe, b_oe;
  logic          src_sel, a_drv_n, b_drv_n;
  logic          ce_lo1_n, ce_lo2_n, ce_hi_n, ce_ba_lo_n, ce_ba_hi_n;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  narrow_wide_xchg #(.NW(NW)) i_narrow_wide_xchg (
    .clk(clk), .rst(rst), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe), .src_sel(src_sel),
    .a_drv_n(a_drv_n), .b_drv_n(b_drv_n), .ce_lo1_n(ce_lo1_n),
    .ce_lo2_n(ce_lo2_n), .ce_hi_n(ce_hi_n), .ce_ba_lo_n(ce_ba_lo_n),
    .ce_ba_hi_n(ce_ba_hi_n)
  );

  task automatic chk(input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference, updated on every rising edge and compared 5 ns later.
  logic [NW-1:0] m_s1 = '0, m_s2 = '0, m_hi = '0, m_blo = '0, m_bhi = '0;
  bit m_sel = 0, m_aoe = 0, m_boe = 0;

  always @(posedge clk) begin : model
    logic [NW-1:0] old_s1;
    old_s1 = m_s1;
    if (rst) begin
      m_s1 = '0; m_s2 = '0; m_hi = '0; m_blo = '0; m_bhi = '0;
      m_sel = 0; m_aoe = 0; m_boe = 0;
    end else begin
      if (!ce_lo1_n)   m_s1  = a_in;
      if (!ce_lo2_n)   m_s2  = old_s1;
      if (!ce_hi_n)    m_hi  = a_in;
      if (!ce_ba_lo_n) m_blo = b_in[NW-1:0];
      if (!ce_ba_hi_n) m_bhi = b_in[WW-1:NW];
      m_sel = src_sel;
      m_aoe = !a_drv_n;
      m_boe = !b_drv_n;
    end
    #5;
    chk("R2 b_out low half",  WW'(b_out[NW-1:0]),  WW'(m_s2));
    chk("R3 b_out high half", WW'(b_out[WW-1:NW]), WW'(m_hi));
    chk("R4 a_out select",    WW'(a_out), WW'(m_sel ? m_bhi : m_blo));
    chk("R5 a_oe",            WW'(a_oe), WW'(m_aoe));
    chk("R5 b_oe",            WW'(b_oe), WW'(m_boe));
  end

  task automatic idle();
    ce_lo1_n = 1; ce_lo2_n = 1; ce_hi_n = 1; ce_ba_lo_n = 1; ce_ba_hi_n = 1;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    rst = 1; a_in = '0; b_in = '0; src_sel = 0; a_drv_n = 0; b_drv_n = 0;
    ce_lo1_n = 0; ce_lo2_n = 0; ce_hi_n = 0; ce_ba_lo_n = 0; ce_ba_hi_n = 0;
    a_in = 12'hFFF; b_in = 24'hFFFFFF;
    repeat (2) @(negedge clk);
    // R7: reset wins over low enables and drive requests
    chk("R7 reset b_out", b_out, '0);
    chk("R7 reset a_out", WW'(a_out), '0);
    chk("R7 reset a_oe", WW'(a_oe), '0);
    chk("R7 reset b_oe", WW'(b_oe), '0);
    rst = 0; idle(); a_drv_n = 1; b_drv_n = 1;

    // R6: pair two narrow words into one wide word
    @(negedge clk); a_in = 12'h5A3; ce_lo1_n = 0;
    @(negedge clk); a_in = 12'hC1E; ce_lo1_n = 0; ce_lo2_n = 0; ce_hi_n = 0;
    @(negedge clk); idle(); a_in = 12'h777;
    chk("R6 paired word", b_out, 24'hC1E5A3);
    repeat (4) @(negedge clk);
    // R1: held while enables are high even with a_in moving
    chk("R1 pair held", b_out, 24'hC1E5A3);

    // R8 and R4: capture both halves of B, then switch select
    b_in = 24'hABC123; ce_ba_lo_n = 0; ce_ba_hi_n = 0; src_sel = 0; a_drv_n = 0;
    @(negedge clk); idle(); b_in = 24'h000000;
    chk("R8 1B capture on a_out", WW'(a_out), WW'(12'h123));
    chk("R5 a_oe on after edge", WW'(a_oe), WW'(1'b1));
    src_sel = 1;
    #5 chk("R4 select not yet applied", WW'(a_out), WW'(12'h123));
    @(negedge clk);
    chk("R4 2B capture on a_out", WW'(a_out), WW'(12'hABC));

    // R5: direction change waits for the edge
    a_drv_n = 1; b_drv_n = 0;
    #5 chk("R5 b_oe before edge", WW'(b_oe), WW'(1'b0));
    chk("R5 a_oe before edge", WW'(a_oe), WW'(1'b1));
    @(negedge clk);
    chk("R5 b_oe after edge", WW'(b_oe), WW'(1'b1));
    chk("R5 a_oe after edge", WW'(a_oe), WW'(1'b0));

    // R7: reset in mid-run
    rst = 1;
    @(negedge clk); rst = 0;
    chk("R7 mid-run b_out", b_out, '0);
    chk("R7 mid-run b_oe", WW'(b_oe), '0);

    // Random traffic, compared against the reference on every edge
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      a_in       = NW'($urandom);
      b_in       = WW'({$urandom, $urandom});
      src_sel    = 1'($urandom);
      a_drv_n    = 1'($urandom);
      b_drv_n    = 1'($urandom);
      ce_lo1_n   = 1'($urandom);
      ce_lo2_n   = 1'($urandom);
      ce_hi_n    = 1'($urandom);
      ce_ba_lo_n = 1'($urandom);
      ce_ba_hi_n = 1'($urandom);
      rst        = ($urandom % 64) == 0;
    end
    @(negedge clk); rst = 0; idle();
    @(negedge clk);
    summary();
    $finish;
  end

endmodule